// File: doc/BRIEF.md
# ADC Conversion and Sleep Sequencer

This block is the digital control core of a 12-bit sampling converter with a parallel result bus. An active-low start strobe ends the track phase and begins a conversion. The block raises a busy flag for a fixed number of clock cycles and drives a track/hold control. When the conversion ends it captures a result word from a stand-in conversion source. A host reads that word over a data bus. The bus is enabled only while both an active-low chip select and an active-low read strobe are asserted.

The start strobe can also put the block to sleep. If the strobe is still low on the clock edge where the conversion completes, the block sleeps instead of returning to track. A select input, sampled at that moment, picks the sleep depth. Partial sleep turns off only the analog enable. Full sleep also turns off the reference/oscillator enable. The next rising edge of the strobe starts a wake-up interval, and its length depends on the sleep depth. Start edges that arrive during a conversion or during wake-up have no effect.

All inputs are assumed to be synchronous to `clk`. A start pulse that is low for a single clock edge is enough. At 250 MHz, any 10 ns pulse covers at least two edges.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, busy = 0, hold = 0 (track), data_oe = 0, data_out = 0, analog_en = 1 and ref_osc_en = 1.
- R2: A start falling edge is detected as start high on one clock edge and low on the next. When it is detected in the track state, busy = 1 and hold = 1 from the following cycle. Busy then stays high for exactly CONV_CYCLES cycles. A start that is low for only one sampled edge is accepted.
- R3: Hold returns to 0 one cycle before busy falls, so hold is high for CONV_CYCLES-1 cycles of each conversion.
- R4: The result register takes conv_data on the clock edge where busy falls. A read during a conversion returns the previous result.
- R5: If start is low on the edge where busy falls, the block sleeps and analog_en = 0. Otherwise it returns to track with analog_en = 1. Busy is never high while analog_en = 0.
- R6: sleep_full is sampled when sleep is entered. With sleep_full = 1, ref_osc_en = 0 during sleep. With sleep_full = 0, ref_osc_en stays 1.
- R7: While asleep, a start rising edge sets analog_en = 1 and ref_osc_en = 1 from the next cycle. A wake interval of D cycles then follows, where D = WAKE_FULL for full sleep and WAKE_PART for partial sleep. Counting the waking edge as edge 0, a start falling edge sampled on edges 1 to D is ignored. A falling edge sampled on edge D+1 or later starts a conversion.
- R8: A start falling edge during a conversion is ignored: the busy length does not change and no second conversion follows.
- R9: data_oe = 1 exactly when cs_n = 0 and rd_n = 0, and the two strobes are interchangeable. While data_oe = 0, data_out is all zeros. While data_oe = 1, data_out shows the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Active-low conversion start / sleep hold strobe |
| sleep_full | input | 1 | Sleep depth select: 1 full, 0 partial |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| conv_data | input | DATA_W | Result word from the stand-in conversion source |
| busy | output | 1 | High while a conversion runs |
| hold | output | 1 | Track/hold control: 1 hold, 0 track |
| data_oe | output | 1 | Data bus output enable |
| data_out | output | DATA_W | Result bus, zero when not enabled |
| analog_en | output | 1 | Power enable for the analog core |
| ref_osc_en | output | 1 | Power enable for reference and oscillator |

## Verification
Counting the detecting edge as E0, busy and hold are due in the cycle after E0. Busy falls after edge E(CONV_CYCLES), and hold falls one cycle earlier. The sleep decision, the power enables and the new result show on the bus at that same busy fall. The enables come back in the cycle after the edge that samples the waking rise. The bench drives every input on the falling clock edge and samples at that falling edge or shortly after, so each check reads the registered state between two rising edges. Each check's cycle is counted from the edge that sampled the stimulus. The data bus is combinational, so it is checked 1 ns after cs_n and rd_n change. Wake-up is checked at the ports by placing a start falling edge on edge D or on edge D+1 after the waking edge, then checking whether busy rises.

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 14,
  parameter int WAKE_PART   = 4,
  parameter int WAKE_FULL   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start_n,
  input  logic              sleep_full,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] conv_data,
  output logic              busy,
  output logic              hold,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              analog_en,
  output logic              ref_osc_en
);
  localparam int MAX_CNT = (CONV_CYCLES > WAKE_FULL) ? CONV_CYCLES : WAKE_FULL;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WAKE_PART - 1);
  localparam logic [CNT_W-1:0] WF_LOAD   = CNT_W'(WAKE_FULL - 1);

  typedef enum logic [1:0] {ST_TRACK, ST_CONV, ST_SLEEP, ST_WAKE} st_t;

  st_t               state;
  logic [CNT_W-1:0]  cnt;
  logic              start_q;
  logic              full_q;
  logic [DATA_W-1:0] res_q;

  wire start_fall = start_q & ~conv_start_n;
  wire start_rise = ~start_q & conv_start_n;
  wire cnt_done   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_TRACK;
      cnt     <= '0;
      start_q <= 1'b1;
      full_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      start_q <= conv_start_n;
      case (state)
        ST_TRACK: if (start_fall) begin
          state <= ST_CONV;
          cnt   <= CONV_LOAD;
        end
        ST_CONV: if (cnt_done) begin
          res_q <= conv_data;
          if (!conv_start_n) begin
            state  <= ST_SLEEP;
            full_q <= sleep_full;
          end else begin
            state <= ST_TRACK;
          end
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
        ST_SLEEP: if (start_rise) begin
          state <= ST_WAKE;
          cnt   <= full_q ? WF_LOAD : WP_LOAD;
        end
        ST_WAKE: if (cnt_done) state <= ST_TRACK;
                 else          cnt   <= cnt - CNT_W'(1);
        default: state <= ST_TRACK;
      endcase
    end
  end

  assign busy       = (state == ST_CONV);
  assign hold       = busy && !cnt_done;
  assign analog_en  = (state != ST_SLEEP);
  assign ref_osc_en = !((state == ST_SLEEP) && full_q);
  assign data_oe    = ~cs_n & ~rd_n;
  assign data_out   = data_oe ? res_q : '0;

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRACK && start_fall) |=> (busy && hold));
  assert_track_before_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(hold));
  assert_result_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $fell(busy));
  assert_no_busy_asleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !analog_en |-> !busy);
  assert_full_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_osc_en |-> !analog_en);
  assert_wake_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && start_rise) |=> (analog_en && ref_osc_en && !busy));
  assert_conv_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold) |=> busy);
  assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  localparam int DW = 12, CC = 14, WP = 4, WF = 24;

  logic clk = 1'b0, rst_n = 1'b0, start_n = 1'b1, sfull = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] din = '0;
  wire busy, hold, oe, aen, ren;
  wire [DW-1:0] dout;
  int checks = 0, errors = 0;
  logic [DW-1:0] last_res = '0;

  adc_seq_ctrl #(.DATA_W(DW), .CONV_CYCLES(CC), .WAKE_PART(WP), .WAKE_FULL(WF)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_start_n(start_n), .sleep_full(sfull),
    .cs_n(cs_n), .rd_n(rd_n), .conv_data(din), .busy(busy), .hold(hold),
    .data_oe(oe), .data_out(dout), .analog_en(aen), .ref_osc_en(ren));

  always #2 clk = ~clk;

  function automatic int wake_len(logic f);
    return f ? WF : WP;
  endfunction

  function automatic bit exp_sleep(int width);
    return width > CC;
  endfunction

  task automatic chk_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_check(string req, logic c, logic r);
    cs_n = c; rd_n = r; #1;
    chk_eq({req, " oe"}, int'(oe), int'(!c && !r));
    chk_eq({req, " bus"}, int'(dout), (!c && !r) ? int'(last_res) : 0);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic conv_run(int width, logic full, logic [DW-1:0] d, output bit slept);
    int n;
    bit sl;
    @(negedge clk); din = d; sfull = full; start_n = 1'b0;
    @(negedge clk);
    chk_eq("R2 busy after start", int'(busy), 1);
    read_check("R4 old result during conversion", 1'b0, 1'b0);
    n = 1;
    while (busy === 1'b1 && n <= CC + 3) begin
      chk_eq("R3 hold", int'(hold), (n < CC) ? 1 : 0);
      if (n == width) start_n = 1'b1;
      @(negedge clk); n++;
    end
    chk_eq("R2 busy length", n - 1, CC);
    sl = exp_sleep(width);
    last_res = d;
    read_check("R4 new result", 1'b0, 1'b0);
    chk_eq("R5 sleep entry", int'(aen), int'(!sl));
    chk_eq("R6 sleep depth", int'(ren), int'(!(sl && full)));
    chk_eq("R3 track after busy", int'(hold), 0);
    slept = sl;
  endtask

  task automatic wake_run(logic full, int r, logic [DW-1:0] d);
    int dl;
    bit acc;
    int n;
    dl = wake_len(full);
    repeat (2) @(negedge clk);
    chk_eq("R5 stays asleep", int'(aen), 0);
    din = d;
    start_n = 1'b1;
    @(negedge clk);
    chk_eq("R7 analog on at wake", int'(aen), 1);
    chk_eq("R7 ref on at wake", int'(ren), 1);
    repeat (r - 1) @(negedge clk);
    start_n = 1'b0;
    acc = (r >= dl + 1);
    @(negedge clk);
    chk_eq("R7 start accepted after wake", int'(busy), int'(acc));
    start_n = 1'b1;
    if (acc) begin
      n = 1;
      while (busy === 1'b1 && n <= CC + 3) begin @(negedge clk); n++; end
      chk_eq("R7 conversion after wake", n - 1, CC);
      last_res = d;
      read_check("R7 result after wake", 1'b0, 1'b0);
    end else begin
      repeat (dl + 2) begin
        @(negedge clk);
        chk_eq("R7 start ignored while waking", int'(busy), 0);
      end
    end
  endtask

  task automatic conv_retrig(logic [DW-1:0] d);
    int n;
    @(negedge clk); din = d; start_n = 1'b0;
    @(negedge clk); start_n = 1'b1;
    n = 1;
    while (busy === 1'b1 && n <= CC + 3) begin
      if (n == 4) start_n = 1'b0;
      if (n == 5) start_n = 1'b1;
      @(negedge clk); n++;
    end
    chk_eq("R8 busy length with extra start", n - 1, CC);
    last_res = d;
    repeat (3) begin
      @(negedge clk);
      chk_eq("R8 no second conversion", int'(busy), 0);
    end
  endtask

  initial begin
    bit sl;
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk_eq("R1 busy", int'(busy), 0);
    chk_eq("R1 hold", int'(hold), 0);
    chk_eq("R1 oe", int'(oe), 0);
    chk_eq("R1 bus", int'(dout), 0);
    chk_eq("R1 analog_en", int'(aen), 1);
    chk_eq("R1 ref_osc_en", int'(ren), 1);
    rst_n = 1'b1;
    @(negedge clk);
    conv_run(1, 1'b0, 12'hA5C, sl);
    read_check("R9 cs only", 1'b0, 1'b1);
    read_check("R9 rd only", 1'b1, 1'b0);
    read_check("R9 neither", 1'b1, 1'b1);
    read_check("R9 both", 1'b0, 1'b0);
    conv_run(CC, 1'b1, 12'h3F0, sl);
    conv_run(CC + 1, 1'b0, 12'h001, sl);
    wake_run(1'b0, WP, 12'h777);
    conv_run(CC + 2, 1'b1, 12'hFFF, sl);
    wake_run(1'b1, WF + 1, 12'h123);
    conv_run(CC + 1, 1'b1, 12'h456, sl);
    wake_run(1'b1, WF, 12'h789);
    conv_retrig(12'h9AB);
    for (int i = 0; i < 30; i++) begin
      int w;
      logic f;
      logic [DW-1:0] d;
      w = $urandom_range(1, CC + 4);
      f = 1'($urandom_range(0, 1));
      d = DW'($urandom);
      conv_run(w, f, d, sl);
      if (sl) wake_run(f, $urandom_range(1, wake_len(f) + 3), DW'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule